// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

This block settles the outcome of one conditional branch per cycle for a pipeline that always executes one instruction after a branch before any change of control takes effect. Each cycle it receives two register operands, a branch kind, a link flag, a likely flag, the branch's own address, a 16-bit displacement, and a floating-point condition bit with its sense selector.

It answers one cycle later. The answer is a fetch redirect with its address, a cancel signal for the instruction after the branch, and a return-address write. The jump target is measured from the instruction that follows the branch, not from the branch itself. Every operand comparison is two's-complement. A likely branch that does not go cancels the instruction that follows it.

Top module: `branch_resolve`

## Requirements
- R1: While reset is held, and at the first clock edge after it, `redir_valid`, `nullify` and `link_we` are 0, and `redir_addr` and `link_val` are zero.
- R2: A taken branch sets `redir_valid` one cycle after the input, with `redir_addr` = `pc` + 4 + (sign-extended `offset` shifted left by 2).
- R3: Kind 1 (equal) is taken when the two 64-bit operands are equal. Kind 2 (not equal) is taken when they differ.
- R4: Kinds 3 (opa >= 0), 4 (opa > 0), 5 (opa <= 0) and 6 (opa < 0) treat `opa` as a signed two's-complement value.
- R5: A valid branch with `link` set raises `link_we` one cycle later with `link_val` = `pc` + 8. This happens whether or not the branch is taken.
- R6: A not-taken branch with `likely` set raises `nullify` and `redir_valid`, with `redir_addr` = `pc` + 8.
- R7: A not-taken branch with `likely` clear gives `redir_valid` = 0 and `nullify` = 0.
- R8: Kind 7 (floating-point condition) is taken when `fp_cond` equals `fp_sense`. The same target, likely and link rules then apply.
- R9: When `in_valid` is low, or when the kind is 0, there is no redirect, no nullify and no link write, even if `link` or `likely` is set.
- R10: A taken likely branch never raises `nullify`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch inputs are valid this cycle |
| kind | input | 3 | Branch kind: 0 none, 1 eq, 2 ne, 3 gez, 4 gtz, 5 lez, 6 ltz, 7 fp |
| link | input | 1 | Write the return address |
| likely | input | 1 | Cancel the next instruction when not taken |
| fp_cond | input | 1 | Floating-point condition bit |
| fp_sense | input | 1 | Condition value that makes kind 7 taken |
| pc | input | 64 | Address of the branch instruction |
| offset | input | 16 | Word displacement |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| redir_valid | output | 1 | Redirect fetch to `redir_addr` |
| redir_addr | output | 64 | Redirect address |
| nullify | output | 1 | Cancel the instruction after the branch |
| link_we | output | 1 | Return-address write enable |
| link_val | output | 64 | Return address |

## Verification
The decision and the target are held in a single register stage. A wrong compare, sign, or base address therefore shows at the ports exactly one cycle after the branch is presented. It appears as a wrong `redir_valid`/`nullify` pair or a wrong `redir_addr`. The bench drives random operands mixed with directed sign-boundary and displacement-boundary cases. It checks every output in the following cycle, so any fault appears at once and is not masked by later branches.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    kind,
  input  logic          link,
  input  logic          likely,
  input  logic          fp_cond,
  input  logic          fp_sense,
  input  logic [AW-1:0] pc,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          redir_valid,
  output logic [AW-1:0] redir_addr,
  output logic          nullify,
  output logic          link_we,
  output logic [AW-1:0] link_val
);
  localparam int SH  = 2;
  localparam int EXT = AW - OW - SH;

  logic signed [DW-1:0] sa;
  logic          is_br, take;
  logic [AW-1:0] slot_addr, fall_addr, tgt_addr, disp;

  assign sa        = opa;
  assign is_br     = in_valid && (kind != 3'd0);
  assign disp      = {{EXT{offset[OW-1]}}, offset, {SH{1'b0}}};
  assign slot_addr = pc + AW'(4);
  assign fall_addr = pc + AW'(8);
  assign tgt_addr  = slot_addr + disp;

  always_comb begin
    case (kind)
      3'd1:    take = (opa == opb);
      3'd2:    take = (opa != opb);
      3'd3:    take = (sa >= 0);
      3'd4:    take = (sa > 0);
      3'd5:    take = (sa <= 0);
      3'd6:    take = (sa < 0);
      3'd7:    take = (fp_cond == fp_sense);
      default: take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      nullify     <= 1'b0;
      link_we     <= 1'b0;
      link_val    <= '0;
    end else begin
      redir_valid <= is_br && (take || likely);
      redir_addr  <= !is_br ? '0 : take ? tgt_addr : likely ? fall_addr : '0;
      nullify     <= is_br && likely && !take;
      link_we     <= is_br && link;
      link_val    <= (is_br && link) ? fall_addr : '0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> !redir_valid && !nullify && !link_we);

  a_r6_nullify_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    nullify |-> redir_valid && redir_addr == $past(pc) + AW'(8));

  a_r5_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_val == $past(pc) + AW'(8) && $past(link));

  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!in_valid) && $past(rst_n) |-> !redir_valid && !nullify && !link_we);

  a_r10_nullify_needs_likely: assert property (@(posedge clk) disable iff (!rst_n)
    nullify |-> $past(likely));
endmodule

// File: tb/test_branch_resolve.sv
module test_branch_resolve;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, link = 0, likely = 0, fp_cond = 0, fp_sense = 0;
  logic [2:0]  kind = 0;
  logic [63:0] pc = 0, opa = 0, opb = 0;
  logic [15:0] offset = 0;
  logic        redir_valid, nullify, link_we;
  logic [63:0] redir_addr, link_val;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  branch_resolve i_branch_resolve (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind), .link(link),
    .likely(likely), .fp_cond(fp_cond), .fp_sense(fp_sense), .pc(pc),
    .offset(offset), .opa(opa), .opb(opb), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .nullify(nullify), .link_we(link_we),
    .link_val(link_val));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_take(input logic [2:0] k, input logic [63:0] a,
                                  input logic [63:0] b, input bit c, input bit s);
    longint sa = a;
    case (k)
      3'd1: return a == b;
      3'd2: return a != b;
      3'd3: return sa >= 0;
      3'd4: return sa > 0;
      3'd5: return sa <= 0;
      3'd6: return sa < 0;
      3'd7: return c == s;
      default: return 0;
    endcase
  endfunction

  task automatic apply(input bit v, input logic [2:0] k, input bit lk, input bit li,
                       input bit c, input bit s, input logic [63:0] p,
                       input logic [15:0] o, input logic [63:0] a, input logic [63:0] b);
    bit br, tk;
    logic [63:0] tgt;
    string dtag;
    @(negedge clk);
    in_valid = v; kind = k; link = lk; likely = li; fp_cond = c; fp_sense = s;
    pc = p; offset = o; opa = a; opb = b;
    br  = v && (k != 0);
    tk  = br && ref_take(k, a, b, c, s);
    tgt = p + 64'd4 + {{46{o[15]}}, o, 2'b00};
    @(negedge clk);
    if (!br) dtag = "R9";
    else if (k == 7) dtag = "R8";
    else if (k <= 2) dtag = "R3";
    else dtag = "R4";
    check({dtag, " redir_valid"}, 64'(redir_valid), 64'(tk || (br && li)));
    if (!br) begin
      check("R9 nullify", 64'(nullify), 0);
      check("R9 link_we", 64'(link_we), 0);
    end else begin
      if (tk) check("R2 redir_addr", redir_addr, tgt);
      if (tk && li) check("R10 nullify", 64'(nullify), 0);
      if (!tk && li) begin
        check("R6 nullify", 64'(nullify), 1);
        check("R6 redir_addr", redir_addr, p + 64'd8);
      end
      if (!tk && !li) check("R7 nullify", 64'(nullify), 0);
      check("R5 link_we", 64'(link_we), 64'(lk));
      if (lk) check("R5 link_val", link_val, p + 64'd8);
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 redir_valid", 64'(redir_valid), 0);
    check("R1 nullify", 64'(nullify), 0);
    check("R1 link_we", 64'(link_we), 0);
    check("R1 link_val", link_val, 0);
    rst_n = 1;
    // directed corners
    apply(1, 3'd1, 0, 0, 0, 0, 64'h1000, 16'h0004, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001);
    apply(1, 3'd2, 0, 1, 0, 0, 64'h1000, 16'h0004, 64'h1, 64'h1);
    apply(1, 3'd3, 1, 0, 0, 0, 64'h2000, 16'h8000, 64'h8000_0000_0000_0000, 0);
    apply(1, 3'd3, 0, 0, 0, 0, 64'h2000, 16'h7fff, 64'h0, 0);
    apply(1, 3'd4, 0, 1, 0, 0, 64'h3000, 16'hffff, 64'h0, 0);
    apply(1, 3'd4, 0, 0, 0, 0, 64'h3000, 16'hffff, 64'h7fff_ffff_ffff_ffff, 0);
    apply(1, 3'd5, 1, 1, 0, 0, 64'h4000, 16'h0010, 64'hffff_ffff_ffff_ffff, 0);
    apply(1, 3'd6, 1, 1, 0, 0, 64'h4000, 16'h0010, 64'h0, 0);
    apply(1, 3'd7, 0, 1, 1, 1, 64'h5000, 16'h0020, 0, 0);
    apply(1, 3'd7, 1, 1, 1, 0, 64'h5000, 16'h0020, 0, 0);
    apply(0, 3'd1, 1, 1, 0, 0, 64'h6000, 16'h0001, 0, 0);
    apply(1, 3'd0, 1, 1, 0, 0, 64'h6000, 16'h0001, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom % 3 == 0) ? a : {$urandom, $urandom};
      if ($urandom % 5 == 0) a = 0;
      apply($urandom % 8 != 0, 3'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), {$urandom, $urandom & 32'hffff_fffc},
            16'($urandom), a, b);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule